// File: doc/BRIEF.md
# Dual-Mode Vertex Texel Fetch Controller

This block serves texel requests issued by a vertex processing stage. Each request carries a 2-D texel coordinate and a mode bit, and the block returns one texel per request. In cache mode it checks a small direct-mapped store of 4×4 texel tiles. On a miss it fetches the whole tile from external memory in one 16-beat burst, writes the tile into the store, and then returns the requested texel. In direct mode a miss fetches only the requested texel with a single-beat read and leaves the store unchanged. A request in either mode that finds its tile already resident is answered from the store, with no external access.

Which mode to use comes from an estimate of spatial locality made upstream. A full tile burst costs about as much as three single reads (8 cycles for one texel, 23 for sixteen). Sparse vertex accesses therefore use direct mode, and dense accesses amortise the burst. The controller handles one request at a time. It has one external transaction in flight at most and returns responses in request order.

Top module: `vtf_fetch_ctrl`

## Requirements
- R1: While reset is applied, and on the cycle after it is released, `req_ready` is 1 and `rsp_valid` and `mem_rd_valid` are 0. Reset marks every store entry empty, so the first cache-mode request to any tile after reset issues a burst.
- R2: A cache-mode request that misses issues exactly one external read with `mem_rd_burst`=1. The address is the tile origin, which has the two low bits of both coordinates cleared. The 16 returned beats are taken in row-major order with u varying fastest: beat k holds texel (origin_u + k mod 4, origin_v + k div 4).
- R3: For a request served by a burst, `rsp_valid` rises only after all 16 beats have been received. `rsp_texel` equals the beat whose in-tile position matches the requested coordinate.
- R4: A request in either mode whose tile is resident produces no external read. It returns the texel held in the store, even if external memory has changed since the fill.
- R5: A direct-mode request that misses issues one read with `mem_rd_burst`=0 at the exact requested coordinate, consumes one beat and returns that beat. It allocates nothing, so a later request to the same tile misses again.
- R6: The store has 8 entries. A tile with block coordinates (bu, bv) = (u div 4, v div 4) lives in entry {bv[0], bu[1:0]}. A cache-mode fill replaces the tile that was in that entry and leaves the other entries untouched.
- R7: From the acceptance of a request (`req_valid` and `req_ready` high at a clock edge) until its response, `req_ready` is 0. `mem_rd_valid`, once raised, holds with a stable address and mode until `mem_rd_ready` accepts it.
- R8: Every accepted request produces exactly one `rsp_valid` pulse, one cycle long. Responses come in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_u | input | COORD_W | Texel u coordinate |
| req_v | input | COORD_W | Texel v coordinate |
| req_cache_mode | input | 1 | 1 = cache mode (allocate by burst), 0 = direct mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_texel | output | TEX_W | Returned texel |
| mem_rd_valid | output | 1 | External read request |
| mem_rd_ready | input | 1 | External read request accepted |
| mem_rd_burst | output | 1 | 1 = 16-beat tile burst, 0 = single texel |
| mem_rd_u | output | COORD_W | Read u coordinate (tile origin for bursts) |
| mem_rd_v | output | COORD_W | Read v coordinate (tile origin for bursts) |
| mem_rsp_valid | input | 1 | Read data beat present |
| mem_rsp_data | input | TEX_W | Read data beat |

## Verification
The hardest condition to reach from the ports is a resident tile whose stored contents differ from what external memory now holds. Without it, a hit and a silent re-read look the same at `rsp_texel`. The bench gives every texel in memory a generation field and advances the generation between phases. A response from a stale tile is therefore distinguishable from a fresh fetch, and the reference model predicts which one each request must return. Set conflicts are forced with tile pairs chosen to share an entry, and a reset in mid-run is followed by a request to a tile that was resident before the reset.

// File: rtl/vtf_pkg.sv
package vtf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOOKUP = 3'd1,
    ST_MEMREQ = 3'd2,
    ST_WAIT   = 3'd3,
    ST_RESP   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/vtf_tag_array.sv
module vtf_tag_array #(
  parameter int NUM_SETS = 8,
  parameter int SET_W    = 3,
  parameter int TAG_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [NUM_SETS-1:0] valid_q;
  logic [TAG_W-1:0]    tag_q [NUM_SETS];

  for (genvar e = 0; e < NUM_SETS; e++) begin : g_entry
    logic ent_we;
    assign ent_we = wr_en && (wr_idx == SET_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
      end else if (ent_we) begin
        valid_q[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (ent_we) begin
        tag_q[e] <= wr_tag;
      end
    end
  end

  always_comb begin
    lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  end
endmodule

// File: rtl/vtf_data_array.sv
module vtf_data_array #(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = 7,
  parameter int TEX_W  = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TEX_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TEX_W-1:0]  rd_data
);
  logic [TEX_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_data = mem_q[rd_addr];
  end
endmodule

// File: rtl/vtf_seq.sv
module vtf_seq
  import vtf_pkg::*;
#(
  parameter int TEX_W    = 32,
  parameter int COORD_W  = 8,
  parameter int BLK_LOG  = 2,
  parameter int NUM_SETS = 8,
  localparam int OFF_W      = 2 * BLK_LOG,
  localparam int BLK_TEXELS = 1 << OFF_W,
  localparam int BC_W       = COORD_W - BLK_LOG,
  localparam int SET_W      = $clog2(NUM_SETS),
  localparam int SET_V_W    = SET_W / 2,
  localparam int SET_U_W    = SET_W - SET_V_W,
  localparam int TAG_W      = 2 * BC_W - SET_W,
  localparam int ADDR_W     = SET_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COORD_W-1:0] req_u,
  input  logic [COORD_W-1:0] req_v,
  input  logic               req_cache_mode,
  output logic               rsp_valid,
  output logic [TEX_W-1:0]   rsp_texel,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic               mem_rd_burst,
  output logic [COORD_W-1:0] mem_rd_u,
  output logic [COORD_W-1:0] mem_rd_v,
  input  logic               mem_rsp_valid,
  input  logic [TEX_W-1:0]   mem_rsp_data,
  output logic [SET_W-1:0]   set_idx,
  output logic [TAG_W-1:0]   set_tag,
  input  logic               lk_hit,
  output logic               tag_we,
  output logic               dat_we,
  output logic [ADDR_W-1:0]  dat_waddr,
  output logic [ADDR_W-1:0]  dat_raddr,
  input  logic [TEX_W-1:0]   dat_rdata
);
  seq_state_e         state_q, state_d;
  logic [COORD_W-1:0] u_q, v_q;
  logic               cmode_q;
  logic [OFF_W-1:0]   beat_q, beat_d;
  logic               beat_en;
  logic [TEX_W-1:0]   texel_q, texel_d;
  logic               texel_en;
  logic               req_load;

  logic [BC_W-1:0]  blk_u, blk_v;
  logic [OFF_W-1:0] in_off;

  always_comb begin
    blk_u   = u_q[COORD_W-1:BLK_LOG];
    blk_v   = v_q[COORD_W-1:BLK_LOG];
    in_off  = {v_q[BLK_LOG-1:0], u_q[BLK_LOG-1:0]};
    set_idx = {blk_v[SET_V_W-1:0], blk_u[SET_U_W-1:0]};
    set_tag = {blk_v[BC_W-1:SET_V_W], blk_u[BC_W-1:SET_U_W]};
    dat_raddr = {set_idx, in_off};
    dat_waddr = {set_idx, beat_q};
  end

  // next-state and datapath control
  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    beat_en   = 1'b0;
    texel_d   = texel_q;
    texel_en  = 1'b0;
    req_load  = 1'b0;
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    mem_rd_valid = 1'b0;
    tag_we    = 1'b0;
    dat_we    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          req_load = 1'b1;
          state_d  = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lk_hit) begin
          texel_d  = dat_rdata;
          texel_en = 1'b1;
          state_d  = ST_RESP;
        end else begin
          state_d  = ST_MEMREQ;
        end
      end
      ST_MEMREQ: begin
        mem_rd_valid = 1'b1;
        if (mem_rd_ready) begin
          beat_d  = '0;
          beat_en = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (cmode_q) begin
            dat_we  = 1'b1;
            beat_d  = beat_q + OFF_W'(1);
            beat_en = 1'b1;
            if (beat_q == in_off) begin
              texel_d  = mem_rsp_data;
              texel_en = 1'b1;
            end
            if (beat_q == OFF_W'(BLK_TEXELS - 1)) begin
              tag_we  = 1'b1;
              state_d = ST_RESP;
            end
          end else begin
            texel_d  = mem_rsp_data;
            texel_en = 1'b1;
            state_d  = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        rsp_valid = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_rd_burst = cmode_q;
    if (cmode_q) begin
      mem_rd_u = {blk_u, {BLK_LOG{1'b0}}};
      mem_rd_v = {blk_v, {BLK_LOG{1'b0}}};
    end else begin
      mem_rd_u = u_q;
      mem_rd_v = v_q;
    end
    rsp_texel = texel_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_load) begin
      u_q     <= req_u;
      v_q     <= req_v;
      cmode_q <= req_cache_mode;
    end
    if (beat_en) begin
      beat_q <= beat_d;
    end
    if (texel_en) begin
      texel_q <= texel_d;
    end
  end
endmodule

// File: rtl/vtf_fetch_ctrl.sv
module vtf_fetch_ctrl #(
  parameter int TEX_W    = 32,
  parameter int COORD_W  = 8,
  parameter int BLK_LOG  = 2,
  parameter int NUM_SETS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COORD_W-1:0] req_u,
  input  logic [COORD_W-1:0] req_v,
  input  logic               req_cache_mode,
  output logic               rsp_valid,
  output logic [TEX_W-1:0]   rsp_texel,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic               mem_rd_burst,
  output logic [COORD_W-1:0] mem_rd_u,
  output logic [COORD_W-1:0] mem_rd_v,
  input  logic               mem_rsp_valid,
  input  logic [TEX_W-1:0]   mem_rsp_data
);
  localparam int OFF_W      = 2 * BLK_LOG;
  localparam int BLK_TEXELS = 1 << OFF_W;
  localparam int BC_W       = COORD_W - BLK_LOG;
  localparam int SET_W      = $clog2(NUM_SETS);
  localparam int TAG_W      = 2 * BC_W - SET_W;
  localparam int ADDR_W     = SET_W + OFF_W;
  localparam int DEPTH      = NUM_SETS * BLK_TEXELS;

  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  set_tag;
  logic              lk_hit;
  logic              tag_we;
  logic              dat_we;
  logic [ADDR_W-1:0] dat_waddr;
  logic [ADDR_W-1:0] dat_raddr;
  logic [TEX_W-1:0]  dat_rdata;

  vtf_seq #(
    .TEX_W(TEX_W), .COORD_W(COORD_W), .BLK_LOG(BLK_LOG), .NUM_SETS(NUM_SETS)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_u(req_u), .req_v(req_v), .req_cache_mode(req_cache_mode),
    .rsp_valid(rsp_valid), .rsp_texel(rsp_texel),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_burst(mem_rd_burst), .mem_rd_u(mem_rd_u), .mem_rd_v(mem_rd_v),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .set_idx(set_idx), .set_tag(set_tag), .lk_hit(lk_hit),
    .tag_we(tag_we), .dat_we(dat_we),
    .dat_waddr(dat_waddr), .dat_raddr(dat_raddr), .dat_rdata(dat_rdata)
  );

  vtf_tag_array #(
    .NUM_SETS(NUM_SETS), .SET_W(SET_W), .TAG_W(TAG_W)
  ) tags_i (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(set_idx), .lk_tag(set_tag), .lk_hit(lk_hit),
    .wr_en(tag_we), .wr_idx(set_idx), .wr_tag(set_tag)
  );

  vtf_data_array #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TEX_W(TEX_W)
  ) data_i (
    .clk(clk),
    .wr_en(dat_we), .wr_addr(dat_waddr), .wr_data(mem_rsp_data),
    .rd_addr(dat_raddr), .rd_data(dat_rdata)
  );
endmodule

// File: rtl/vtf_checker.sv
module vtf_checker #(
  parameter int COORD_W = 8,
  parameter int BLK_LOG = 2,
  localparam int BLK_TEXELS = 1 << (2 * BLK_LOG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               mem_rd_valid,
  input logic               mem_rd_ready,
  input logic               mem_rd_burst,
  input logic [COORD_W-1:0] mem_rd_u,
  input logic [COORD_W-1:0] mem_rd_v,
  input logic               mem_rsp_valid
);
  logic        pend_q;
  logic        pend_burst_q;
  logic [7:0]  beats_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      pend_burst_q <= 1'b0;
      beats_q      <= '0;
    end else begin
      if (mem_rd_valid && mem_rd_ready) begin
        pend_q       <= 1'b1;
        pend_burst_q <= mem_rd_burst;
        beats_q      <= '0;
      end else if (mem_rsp_valid) begin
        beats_q <= beats_q + 8'd1;
      end
      if (rsp_valid) begin
        pend_q       <= 1'b0;
        pend_burst_q <= 1'b0;
      end
    end
  end

  assert_burst_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_burst) |->
      (mem_rd_u[BLK_LOG-1:0] == '0) && (mem_rd_v[BLK_LOG-1:0] == '0));

  assert_fill_before_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pend_burst_q) |-> (beats_q == 8'(BLK_TEXELS)));

  assert_single_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pend_q && !pend_burst_q) |-> (beats_q == 8'd1));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_mem_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=>
      (mem_rd_valid && $stable(mem_rd_u) && $stable(mem_rd_v) && $stable(mem_rd_burst)));

  assert_no_accept_during_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind vtf_fetch_ctrl vtf_checker #(.COORD_W(COORD_W), .BLK_LOG(BLK_LOG)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_burst(mem_rd_burst), .mem_rd_u(mem_rd_u), .mem_rd_v(mem_rd_v),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/vtf_fetch_ctrl_tb_top.sv
`timescale 1ns/1ps
module vtf_fetch_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_u;
  logic [7:0]  req_v;
  logic        req_cache_mode;
  logic        rsp_valid;
  logic [31:0] rsp_texel;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic        mem_rd_burst;
  logic [7:0]  mem_rd_u;
  logic [7:0]  mem_rd_v;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int tests = 0;
  int fails = 0;
  int gen = 1;
  int outstanding = 0;
  int resp_beats = 0;

  typedef struct { int u; int v; bit burst; } memx_t;
  typedef struct { logic [31:0] d; bit burst; bit single; string tag; } rspx_t;
  memx_t mem_q[$];
  rspx_t rsp_q[$];

  bit          m_valid [8];
  int          m_blk   [8];
  logic [31:0] m_data  [8][16];

  vtf_fetch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_u(req_u), .req_v(req_v), .req_cache_mode(req_cache_mode),
    .rsp_valid(rsp_valid), .rsp_texel(rsp_texel),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_burst(mem_rd_burst), .mem_rd_u(mem_rd_u), .mem_rd_v(mem_rd_v),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] texel_of(int u, int v);
    return {8'(gen), 8'(u + 3 * v) ^ 8'h3C, 8'(u), 8'(v)};
  endfunction

  function automatic void check(bit ok, string req, string what, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endfunction

  function automatic void summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endfunction

  // external memory responder: 8 cycles to first beat, then one beat per cycle
  initial begin
    mem_rd_ready  = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_valid) begin
        int bu, bv, nb;
        bit bst;
        bu = int'(mem_rd_u); bv = int'(mem_rd_v); bst = mem_rd_burst;
        nb = bst ? 16 : 1;
        resp_beats   = 0;
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        repeat (6) @(negedge clk);
        for (int k = 0; k < nb; k++) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = bst ? texel_of(bu + k % 4, bv + k / 4) : texel_of(bu, bv);
          resp_beats++;
          @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // reference model and comparison, sampled between the edges
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (rsp_valid) begin
          if (rsp_q.size() == 0) begin
            check(0, "R8", "unexpected response", rsp_texel, 32'h0);
          end else begin
            rspx_t e;
            e = rsp_q.pop_front();
            check(rsp_texel == e.d, e.tag, "texel", rsp_texel, e.d);
            if (e.burst) check(resp_beats == 16, "R3", "beats before response", 32'(resp_beats), 32'd16);
            if (e.single) check(resp_beats == 1, "R5", "beats before response", 32'(resp_beats), 32'd1);
          end
          outstanding--;
        end
        if (mem_rd_valid && mem_rd_ready) begin
          if (mem_q.size() == 0) begin
            check(0, "R4", "unexpected external read", {mem_rd_u, mem_rd_v}, 32'h0);
          end else begin
            memx_t m;
            m = mem_q.pop_front();
            check(mem_rd_burst == m.burst, m.burst ? "R2" : "R5", "read kind", 32'(mem_rd_burst), 32'(m.burst));
            check(mem_rd_u == 8'(m.u) && mem_rd_v == 8'(m.v), m.burst ? "R2" : "R5", "read address",
                  {16'h0, mem_rd_u, mem_rd_v}, {16'h0, 8'(m.u), 8'(m.v)});
          end
        end
        if (outstanding > 0 && req_ready) check(0, "R7", "ready while busy", 32'(req_ready), 32'd0);
        if (req_valid && req_ready) begin
          int u, v, bu, bv, s;
          rspx_t e;
          u = int'(req_u); v = int'(req_v);
          bu = u / 4; bv = v / 4;
          s = ((bv % 2) << 2) | (bu % 4);
          e.burst = 0; e.single = 0;
          if (m_valid[s] && m_blk[s] == bu + 64 * bv) begin
            e.d = m_data[s][(v % 4) * 4 + (u % 4)];
            e.tag = "R4";
          end else if (req_cache_mode) begin
            mem_q.push_back('{u: bu * 4, v: bv * 4, burst: 1'b1});
            for (int k = 0; k < 16; k++) m_data[s][k] = texel_of(bu * 4 + k % 4, bv * 4 + k / 4);
            m_valid[s] = 1'b1;
            m_blk[s]   = bu + 64 * bv;
            e.d = texel_of(u, v);
            e.burst = 1;
            e.tag = "R2/R3/R6";
          end else begin
            mem_q.push_back('{u: u, v: v, burst: 1'b0});
            e.d = texel_of(u, v);
            e.single = 1;
            e.tag = "R5";
          end
          rsp_q.push_back(e);
          outstanding++;
        end
      end
    end
  end

  task automatic send(int u, int v, bit cm);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_u = 8'(u); req_v = 8'(v); req_cache_mode = cm;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (outstanding != 0 || mem_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 8; k++) m_valid[k] = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    check(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check(mem_rd_valid == 1'b0, "R1", "mem_rd_valid in reset", 32'(mem_rd_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(req_ready == 1'b1 && !rsp_valid && !mem_rd_valid, "R1", "idle after release",
          {29'h0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WATCHDOG", "run did not finish", 32'h0, 32'h0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_u = '0; req_v = '0; req_cache_mode = 1'b0;
    for (int k = 0; k < 8; k++) m_valid[k] = 1'b0;
    do_reset();

    // R2 R3: cache-mode miss fills tile (1,1); R4 hits in both modes
    send(5, 6, 1'b1);
    send(7, 4, 1'b1);
    send(4, 7, 1'b0);
    drain();

    // R5: direct misses allocate nothing
    send(20, 40, 1'b0);
    send(21, 40, 1'b0);
    send(22, 41, 1'b1);
    drain();

    // R4: memory changes, resident tiles still answer with stored texels
    gen = 2;
    send(6, 5, 1'b0);
    send(23, 43, 1'b1);
    drain();

    // R6: tile (5,3) shares entry 5 with tile (1,1); tile (5,10) in entry 1 survives
    send(21, 13, 1'b1);
    send(5, 6, 1'b1);
    send(20, 42, 1'b0);
    drain();

    // R1: reset mid-run empties the store
    do_reset();
    gen = 3;
    send(5, 6, 1'b1);
    send(22, 41, 1'b0);
    drain();

    // mixed sweep over a small area, generation advanced between groups
    for (int g = 0; g < 6; g++) begin
      gen = 4 + g;
      for (int n = 0; n < 25; n++) begin
        send(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
      end
      drain();
    end

    check(rsp_q.size() == 0, "R8", "responses missing", 32'(rsp_q.size()), 32'd0);
    check(mem_q.size() == 0, "R8", "reads missing", 32'(mem_q.size()), 32'd0);
    summary();
    $finish;
  end
endmodule